// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This block decides, for an I2C slave, whether an incoming address byte belongs to it. It keeps a small configuration set: a clock-range code, the 7/10-bit addressing choice, the ten bits of the own address, and a programmable general-call address. Software writes and reads these over a simple byte-wide register port. The bit-level side of the slave hands over each received address byte with a strobe. A flag marks the first byte after a START. One cycle later the block pulses an own-address match, a general-call match, and an acknowledge request that combines the two.

Changes to the addressing mode, the clock-range code and the general-call address are refused while the peripheral enable input is high. The own address stays writable at all times, and dropping the enable does not clear it. The clock-range code is checked as it is written. An illegal code is not stored, and it raises a sticky error flag that can be read back. The general-call comparison ignores the least significant bit of the received byte. The byte 01h is never acknowledged.

The matcher is a two-state machine. In IDLE it examines first bytes. A 7-bit own match or a general-call match fires at once. In 10-bit mode, a first byte equal to the header 11110, followed by own bits 9:8 and the R/W bit, is the transition IDLE to HDR_OK and produces no pulse. HDR_OK waits for the next byte. A following non-first byte equal to own bits 7:0 pulses the own match and is the transition HDR_OK to IDLE. A non-first byte that does not match also takes HDR_OK to IDLE. A new first byte is evaluated afresh. Clearing the enable forces IDLE.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset the config register (offset 0) and own-low register (offset 1) read 00h, the general-call register (offset 2) reads A0h, offset 3 reads 00h, and all match outputs are low.
- R2: While periph_enable is 1, writes to the clock-range code, the mode bit and the general-call register are ignored. Own-address bits 9:0 can be written whatever the enable.
- R3: Config register layout: bit 7 = freq[1], bit 6 = freq[0], bit 5 = mode (1 = 10-bit), bit 4 = freq[2], bit 3 = sticky frequency error, bits 2:1 = own[9:8], bit 0 reads 0.
- R4: Frequency codes 0 to 3 are legal and are stored. An unlocked config write with a code of 4 to 7 leaves the stored code unchanged and sets the error bit. The next unlocked config write with a legal code clears the error bit.
- R5: In 7-bit mode, a first byte whose bits 7:1 equal own-low bits 7:1 pulses own_match for exactly the one cycle after the strobe.
- R6: A first byte whose bits 7:1 equal general-call bits 7:1 pulses gcall_match for the cycle after the strobe. The received bit 0 does not matter.
- R7: A received byte of 01h never produces own_match, gcall_match or ack_req, whatever the register contents.
- R8: In 10-bit mode, a header byte alone gives no pulse. A non-first byte equal to own[7:0] that directly follows a matching header pulses own_match. A byte that differs gives nothing. A non-first byte with no header before it gives nothing.
- R9: Own-address bits 9:0 keep their value when periph_enable goes from 1 to 0.
- R10: While periph_enable is 0 no match pulses occur. ack_req is high exactly in the cycles where own_match or gcall_match is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_enable | input | 1 | Peripheral enable; locks configuration when high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 config, 1 own low, 2 general call) |
| reg_wdata | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data for reg_addr (combinational) |
| addr_valid | input | 1 | Received address byte strobe |
| addr_first | input | 1 | Byte is the first after a START |
| addr_byte | input | 8 | Received byte |
| own_match | output | 1 | Own-address match pulse |
| gcall_match | output | 1 | General-call match pulse |
| ack_req | output | 1 | Acknowledge request |
| freq_sel | output | 2 | Stored clock-range code |
| freq_err | output | 1 | Sticky illegal-frequency flag |

## Verification
A register write takes effect at the clock edge where the strobe is sampled. Read data is combinational, so the bench samples it at the falling edge that follows. A match pulse is due exactly one edge after the edge that samples addr_valid. The bench samples it at the next falling edge, then checks that it is gone one cycle later. The 10-bit header sets state at its own edge, and the second byte's result is due one edge after the second strobe. All bench inputs change on falling edges, so every sample falls half a period after the edge it depends on.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W   = 8;
    localparam int RA_W     = 2;
    localparam int FREQ_W   = 3;
    localparam int OWN_W    = 10;
    localparam int N_LEGAL  = 4;

    localparam logic [RA_W-1:0] RA_CFG = 2'd0;
    localparam logic [RA_W-1:0] RA_OWN = 2'd1;
    localparam logic [RA_W-1:0] RA_GC  = 2'd2;

    localparam logic [4:0]        HDR10_PREFIX  = 5'b11110;
    localparam logic [BYTE_W-1:0] RESERVED_BYTE = 8'h01;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_HDR_OK = 1'b1
    } am_state_e;

    typedef struct packed {
        logic hit_own7;
        logic hit_gc;
        logic hit_hdr;
        logic hit_low;
        logic reserved;
    } cmp_hits_t;

    function automatic logic freq_is_legal(input logic [FREQ_W-1:0] code);
        return (int'(code) < N_LEGAL);
    endfunction

endpackage

// File: rtl/i2c_am_cfg_regs.sv
module i2c_am_cfg_regs
    import i2c_am_pkg::*;
#(
    parameter logic [BYTE_W-1:0] GC_RESET = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              mode_10b,
    output logic [OWN_W-1:0]  own_addr,
    output logic [BYTE_W-1:0] gc_addr,
    output logic [FREQ_W-1:0] freq_code,
    output logic              freq_err
);

    logic [FREQ_W-1:0] wr_freq;
    logic              cfg_wr;
    logic              unlocked;

    assign wr_freq  = {wdata[4], wdata[7], wdata[6]};
    assign cfg_wr   = wr_en && (addr == RA_CFG);
    assign unlocked = !enable;

    // own-address high bits: never locked
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_addr <= '0;
        end else if (wr_en) begin
            if (addr == RA_CFG) own_addr[9:8] <= wdata[2:1];
            if (addr == RA_OWN) own_addr[7:0] <= wdata;
        end
    end

    // locked configuration fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_10b  <= 1'b0;
            freq_code <= '0;
            freq_err  <= 1'b0;
            gc_addr   <= GC_RESET;
        end else if (unlocked && wr_en) begin
            if (cfg_wr) begin
                mode_10b <= wdata[5];
                if (freq_is_legal(wr_freq)) begin
                    freq_code <= wr_freq;
                    freq_err  <= 1'b0;
                end else begin
                    freq_err  <= 1'b1;
                end
            end
            if (addr == RA_GC) gc_addr <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_CFG: rdata = {freq_code[1], freq_code[0], mode_10b, freq_code[2],
                             freq_err, own_addr[9:8], 1'b0};
            RA_OWN: rdata = own_addr[7:0];
            RA_GC:  rdata = gc_addr;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic [BYTE_W-1:0] gc_addr,
    output cmp_hits_t         hits
);

    always_comb begin
        hits.reserved = (rx_byte == RESERVED_BYTE);
        hits.hit_own7 = (rx_byte[7:1] == own_addr[7:1]);
        hits.hit_gc   = (rx_byte[7:1] == gc_addr[7:1]);
        hits.hit_hdr  = (rx_byte[7:1] == {HDR10_PREFIX, own_addr[9:8]});
        hits.hit_low  = (rx_byte == own_addr[7:0]);
    end

endmodule

// File: rtl/i2c_am_fsm.sv
module i2c_am_fsm
    import i2c_am_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      mode_10b,
    input  logic      strobe,
    input  logic      first,
    input  cmp_hits_t hits,
    output logic      own_hit,
    output logic      gc_hit
);

    am_state_e state_q, state_d;
    logic      own_d, gc_d;

    always_comb begin
        state_d = state_q;
        own_d   = 1'b0;
        gc_d    = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;
        end else if (strobe) begin
            if (first) begin
                state_d = ST_IDLE;
                if (!hits.reserved) begin
                    gc_d = hits.hit_gc;
                    if (mode_10b) begin
                        if (hits.hit_hdr) state_d = ST_HDR_OK;
                    end else begin
                        own_d = hits.hit_own7;
                    end
                end
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = ST_IDLE;
                    ST_HDR_OK: begin
                        state_d = ST_IDLE;
                        own_d   = mode_10b && hits.hit_low && !hits.reserved;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_hit <= 1'b0;
            gc_hit  <= 1'b0;
        end else begin
            own_hit <= own_d;
            gc_hit  <= gc_d;
        end
    end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter logic [BYTE_W-1:0] GC_RESET = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_enable,
    input  logic              reg_wr_en,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rd_data,
    input  logic              addr_valid,
    input  logic              addr_first,
    input  logic [BYTE_W-1:0] addr_byte,
    output logic              own_match,
    output logic              gcall_match,
    output logic              ack_req,
    output logic [1:0]        freq_sel,
    output logic              freq_err
);

    logic              mode_10b_w;
    logic [OWN_W-1:0]  own_addr_w;
    logic [BYTE_W-1:0] gc_addr_w;
    logic [FREQ_W-1:0] freq_code_w;
    cmp_hits_t         hits_w;

    i2c_am_cfg_regs #(.GC_RESET(GC_RESET)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (periph_enable),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rd_data),
        .mode_10b (mode_10b_w),
        .own_addr (own_addr_w),
        .gc_addr  (gc_addr_w),
        .freq_code(freq_code_w),
        .freq_err (freq_err)
    );

    i2c_am_cmp u_cmp (
        .rx_byte (addr_byte),
        .own_addr(own_addr_w),
        .gc_addr (gc_addr_w),
        .hits    (hits_w)
    );

    i2c_am_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (periph_enable),
        .mode_10b(mode_10b_w),
        .strobe  (addr_valid),
        .first   (addr_first),
        .hits    (hits_w),
        .own_hit (own_match),
        .gc_hit  (gcall_match)
    );

    assign ack_req  = own_match | gcall_match;
    assign freq_sel = freq_code_w[1:0];

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       periph_enable,
    input logic       addr_valid,
    input logic [7:0] addr_byte,
    input logic       own_match,
    input logic       gcall_match,
    input logic       ack_req,
    input logic [7:0] gc_q,
    input logic       mode_q,
    input logic [2:0] freq_q
);

    AST_GC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        periph_enable |=> $stable(gc_q)); // R2
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        periph_enable |=> $stable(mode_q)); // R2
    AST_FREQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_q[2]); // R4
    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (own_match || gcall_match) |-> $past(addr_valid)); // R5
    AST_NEVER_01: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_byte == 8'h01) |=> !ack_req); // R7
    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_enable |=> !own_match && !gcall_match); // R10
    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> (own_match || gcall_match)); // R10

endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .periph_enable(periph_enable),
    .addr_valid   (addr_valid),
    .addr_byte    (addr_byte),
    .own_match    (own_match),
    .gcall_match  (gcall_match),
    .ack_req      (ack_req),
    .gc_q         (gc_addr_w),
    .mode_q       (mode_10b_w),
    .freq_q       (freq_code_w)
);

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       periph_enable = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rd_data;
    logic       addr_valid = 1'b0;
    logic       addr_first = 1'b0;
    logic [7:0] addr_byte = 8'd0;
    logic       own_match, gcall_match, ack_req, freq_err;
    logic [1:0] freq_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_match uut (
        .clk(clk), .rst_n(rst_n), .periph_enable(periph_enable),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd_data(reg_rd_data), .addr_valid(addr_valid),
        .addr_first(addr_first), .addr_byte(addr_byte),
        .own_match(own_match), .gcall_match(gcall_match), .ack_req(ack_req),
        .freq_sel(freq_sel), .freq_err(freq_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cfg_byte(input logic [2:0] f, input logic m,
                                            input logic e, input logic [1:0] hi);
        return {f[1], f[0], m, f[2], e, hi, 1'b0};
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rd_data;
    endtask

    // sends one byte; returns {ack, own, gc} in the cycle after the strobe
    task automatic send(input logic first, input logic [7:0] b, output logic [2:0] res);
        @(negedge clk);
        addr_valid = 1'b1; addr_first = first; addr_byte = b;
        @(negedge clk);
        addr_valid = 1'b0; addr_first = 1'b0;
        res = {ack_req, own_match, gcall_match};
    endtask

    task automatic check_quiet(input string req);
        @(negedge clk);
        check(req, {5'd0, ack_req, own_match, gcall_match}, 8'd0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        reg_read(2'd0, d); check("R1 cfg", d, 8'h00);
        reg_read(2'd1, d); check("R1 own", d, 8'h00);
        reg_read(2'd2, d); check("R1 gc", d, 8'hA0);
        reg_read(2'd3, d); check("R1 off3", d, 8'h00);
        check("R1 outs", {5'd0, ack_req, own_match, gcall_match}, 8'd0);
    endtask

    task automatic t_layout_freq();
        logic [7:0] d;
        reg_write(2'd0, cfg_byte(3'd3, 1'b1, 1'b0, 2'b10));
        reg_read(2'd0, d); check("R3 layout", d, cfg_byte(3'd3, 1'b1, 1'b0, 2'b10));
        check("R4 freq_sel", {6'd0, freq_sel}, 8'd3);
        reg_write(2'd0, cfg_byte(3'd6, 1'b0, 1'b0, 2'b01));
        reg_read(2'd0, d); check("R4 illegal", d, cfg_byte(3'd3, 1'b0, 1'b1, 2'b01));
        check("R4 err pin", {7'd0, freq_err}, 8'd1);
        reg_write(2'd0, cfg_byte(3'd1, 1'b0, 1'b0, 2'b00));
        reg_read(2'd0, d); check("R4 clear", d, cfg_byte(3'd1, 1'b0, 1'b0, 2'b00));
    endtask

    task automatic t_lock();
        logic [7:0] d;
        periph_enable = 1'b1;
        reg_write(2'd0, cfg_byte(3'd2, 1'b1, 1'b0, 2'b11));
        reg_read(2'd0, d); check("R2 cfg locked", d, cfg_byte(3'd1, 1'b0, 1'b0, 2'b11));
        reg_write(2'd2, 8'h42);
        reg_read(2'd2, d); check("R2 gc locked", d, 8'hA0);
        reg_write(2'd1, 8'h5A);
        reg_read(2'd1, d); check("R2 own writable", d, 8'h5A);
        @(negedge clk); periph_enable = 1'b0;
        reg_read(2'd0, d); check("R9 hi kept", d, cfg_byte(3'd1, 1'b0, 1'b0, 2'b11));
        reg_read(2'd1, d); check("R9 lo kept", d, 8'h5A);
    endtask

    task automatic t_match7();
        logic [2:0] r;
        periph_enable = 1'b1;
        send(1'b1, 8'h5A, r); check("R5 own even", {5'd0, r}, 8'b110);
        check_quiet("R5 one cycle");
        send(1'b1, 8'h5B, r); check("R5 own odd", {5'd0, r}, 8'b110);
        send(1'b1, 8'h5C, r); check("R5 miss", {5'd0, r}, 8'b000);
        send(1'b1, 8'hA1, r); check("R6 gc A1", {5'd0, r}, 8'b101);
        send(1'b1, 8'hA0, r); check("R6 gc A0", {5'd0, r}, 8'b101);
        send(1'b0, 8'h5A, r); check("R5 non-first", {5'd0, r}, 8'b000);
        periph_enable = 1'b0;
        send(1'b1, 8'h5A, r); check("R10 disabled", {5'd0, r}, 8'b000);
    endtask

    task automatic t_reserved();
        logic [2:0] r;
        reg_write(2'd2, 8'h00);
        reg_write(2'd1, 8'h00);
        periph_enable = 1'b1;
        send(1'b1, 8'h00, r); check("R6 gc 00", {5'd0, r}, 8'b111);
        send(1'b1, 8'h01, r); check("R7 01 rejected", {5'd0, r}, 8'b000);
        periph_enable = 1'b0;
    endtask

    task automatic t_match10();
        logic [2:0] r;
        reg_write(2'd0, cfg_byte(3'd0, 1'b1, 1'b0, 2'b10));
        reg_write(2'd1, 8'hA5);
        reg_write(2'd2, 8'h00);
        periph_enable = 1'b1;
        send(1'b1, 8'hF4, r); check("R8 header quiet", {5'd0, r}, 8'b000);
        send(1'b0, 8'hA5, r); check("R8 full match", {5'd0, r}, 8'b110);
        send(1'b1, 8'hF5, r); check("R8 header rw1", {5'd0, r}, 8'b000);
        send(1'b0, 8'hA4, r); check("R8 low miss", {5'd0, r}, 8'b000);
        send(1'b0, 8'hA5, r); check("R8 no header", {5'd0, r}, 8'b000);
        send(1'b1, 8'hF6, r); check("R8 wrong hi", {5'd0, r}, 8'b000);
        send(1'b0, 8'hA5, r); check("R8 after bad hdr", {5'd0, r}, 8'b000);
        send(1'b1, 8'hA5, r); check("R8 7b byte in 10b", {5'd0, r}, 8'b000);
        periph_enable = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout_freq();
        t_lock();
        t_match7();
        t_reserved();
        t_match10();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule